// File: doc/BRIEF.md
# Packer Circular Line Writer

This block sits at the tail of a packer pipeline. It takes packed output bytes one per beat and collects them in a 16-byte line register. When the line holds 16 bytes, or when a flush or last command arrives, it writes the line to local memory as one aligned 16-byte write. The unused tail of a partial line is filled with zeros. Successive pack operations that do not flush keep filling the same line, so many small operations can share one memory line.

Write addresses are counted in 16-byte lines and cover a circular region. A start address is built from four parts: a destination base, a coarse Y/Z/W offset rounded down to a multiple of 16, an optional extra offset, and a one-line header step that a flag can suppress. The block computes a new start address only when one is needed: after reset, after a last command, or after an explicit request. Each later line takes the next address. Any address above twice the limit plus one is pulled back by twice the region size.

Top module: `pk_line_writer`

## Requirements
- R1: Each write carries 16 bytes on `wr_data`. The n-th accepted byte of a line (n = 0..15) sits at bits [8n+7:8n]. `wr_addr` is a line index in 16-byte units.
- R2: When the 16th byte of a line is accepted on a clock edge, `wr_valid` is high right after that edge. The line is written without any flush.
- R3: A flush or last accepted while the line holds 1 to 15 bytes, counting a byte accepted in the same cycle, writes that line at once. Its unfilled bytes are zero.
- R4: A flush or last accepted while the line is empty writes nothing. A flush that comes with the 16th byte produces exactly one write.
- R5: Bytes from separate beats or bursts go into the same line until the line fills or is flushed. The line after a completed write uses the previous address plus one, with R7 applied.
- R6: The start address is `base + (hdr_skip ? 0 : 1) + (coarse & ~0xF) + (extra_en ? extra : 0)`. It is taken modulo 2^AW after R7.
- R7: If a start address or an incremented address is greater than 2*limit+1, then 2*size is subtracted from it.
- R8: A new start address is taken only at the first byte of a line that follows reset, a last command, or a `new_addr` pulse. Config changes at any other time have no effect on write addresses.
- R9: `wr_valid`, `wr_addr` and `wr_data` hold steady until `wr_ready` is seen high. `in_ready` is low while a write is pending. Bytes, flush and last count only when `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dest_base | input | AW | Destination base line address |
| cfg_coarse_off | input | AW | Y/Z/W offset; low 4 bits ignored |
| cfg_extra_off | input | AW | Optional extra offset |
| cfg_extra_en | input | 1 | Add the extra offset |
| cfg_hdr_skip | input | 1 | Suppress the one-line header step |
| cfg_wrap_limit | input | AW | Wrap limit (threshold 2*limit+1) |
| cfg_wrap_size | input | AW | Region size (2*size subtracted on wrap) |
| new_addr | input | 1 | Request a fresh start address for the next line |
| in_valid | input | 1 | Byte valid |
| in_byte | input | 8 | Packed output byte |
| flush | input | 1 | Close the current line, keep the address sequence |
| last | input | 1 | Close the current line and request a new start address |
| in_ready | output | 1 | Byte, flush and last are accepted |
| wr_valid | output | 1 | Line write pending |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | AW | Line address of the write |
| wr_data | output | 128 | Line contents, byte 0 in the low bits |

## Verification
The assertions assume that `wr_ready` may drop at any time. They also assume that flush, last and bytes are counted only in cycles where `in_ready` is high. The bench drives inputs only after it has seen `in_ready` high at the falling edge. It keeps the configuration and `new_addr` unchanged inside any cycle in which a line loads its start address. The wrap sequences are chosen so that each address stays below 2*limit+1 plus 2*size, which means one subtraction is enough to bring it back into the region.

// File: rtl/pk_pkg.sv
package pk_pkg;
    localparam int PK_BYTE_W      = 8;
    localparam int PK_COARSE_BITS = 4;
    typedef logic [PK_BYTE_W-1:0] pk_byte_t;
endpackage

// File: rtl/pk_addr_gen.sv
module pk_addr_gen #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] coarse,
    input  logic [AW-1:0] extra,
    input  logic          extra_en,
    input  logic          hdr_skip,
    output logic [AW+1:0] raw
);
    import pk_pkg::*;
    localparam int EW = AW + 2;
    localparam logic [AW-1:0] FINE_MASK = AW'((1 << PK_COARSE_BITS) - 1);

    logic [AW-1:0] coarse_m;

    always_comb begin
        coarse_m = coarse & ~FINE_MASK;
        raw = EW'(base) + EW'(coarse_m) + EW'(!hdr_skip)
            + (extra_en ? EW'(extra) : EW'(0));
    end
endmodule

// File: rtl/pk_addr_wrap.sv
module pk_addr_wrap #(
    parameter int AW = 16
) (
    input  logic [AW+1:0] raw,
    input  logic [AW-1:0] limit,
    input  logic [AW-1:0] size,
    output logic [AW-1:0] addr
);
    localparam int EW = AW + 2;

    logic [EW-1:0] thr;
    logic [EW-1:0] dsize;

    always_comb begin
        thr   = {1'b0, limit, 1'b1};
        dsize = {1'b0, size, 1'b0};
        if (raw > thr) addr = AW'(raw - dsize);
        else           addr = AW'(raw);
    end
endmodule

// File: rtl/pk_line_acc.sv
module pk_line_acc #(
    parameter int LINE_BYTES = 16,
    localparam int DW = LINE_BYTES * pk_pkg::PK_BYTE_W,
    localparam int CW = $clog2(LINE_BYTES + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  pk_pkg::pk_byte_t din,
    input  logic           clear,
    output logic [CW-1:0]  fill,
    output logic [DW-1:0]  line
);
    import pk_pkg::*;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [DW-1:0] data;
    } acc_t;

    acc_t acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (clear) begin
            acc_d.cnt  = '0;
            acc_d.data = '0;
        end else if (push) begin
            for (int i = 0; i < LINE_BYTES; i++) begin
                if (acc_q.cnt == CW'(i))
                    acc_d.data[i*PK_BYTE_W +: PK_BYTE_W] = din;
            end
            acc_d.cnt = acc_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign fill = acc_q.cnt;
    assign line = acc_q.data;

    // R2: the line never holds more than its width
    a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(LINE_BYTES));

    // R4: a cleared line starts empty with zeroed storage for padding
    a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (fill == '0) && (line == '0));
endmodule

// File: rtl/pk_line_writer.sv
module pk_line_writer #(
    parameter int AW         = 16,
    parameter int LINE_BYTES = 16,
    localparam int DW = LINE_BYTES * 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cfg_dest_base,
    input  logic [AW-1:0] cfg_coarse_off,
    input  logic [AW-1:0] cfg_extra_off,
    input  logic          cfg_extra_en,
    input  logic          cfg_hdr_skip,
    input  logic [AW-1:0] cfg_wrap_limit,
    input  logic [AW-1:0] cfg_wrap_size,
    input  logic          new_addr,
    input  logic          in_valid,
    input  logic [7:0]    in_byte,
    input  logic          flush,
    input  logic          last,
    output logic          in_ready,
    output logic          wr_valid,
    input  logic          wr_ready,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    import pk_pkg::*;
    localparam int CW = $clog2(LINE_BYTES + 1);
    localparam int EW = AW + 2;

    typedef struct packed {
        logic          pend;
        logic          last_pend;
        logic          need;
        logic [AW-1:0] cur;
    } st_t;

    st_t st_d, st_q;

    logic [CW-1:0] fill;
    logic [DW-1:0] line;
    logic [EW-1:0] start_raw;
    logic [EW-1:0] step_raw;
    logic [AW-1:0] start_addr;
    logic [AW-1:0] step_addr;
    logic          accept, push, close, emit, load, done, clear;
    logic [CW-1:0] fill_after;

    pk_addr_gen #(.AW(AW)) u_gen (
        .base     (cfg_dest_base),
        .coarse   (cfg_coarse_off),
        .extra    (cfg_extra_off),
        .extra_en (cfg_extra_en),
        .hdr_skip (cfg_hdr_skip),
        .raw      (start_raw)
    );

    pk_addr_wrap #(.AW(AW)) u_wrap_start (
        .raw   (start_raw),
        .limit (cfg_wrap_limit),
        .size  (cfg_wrap_size),
        .addr  (start_addr)
    );

    assign step_raw = EW'(st_q.cur) + EW'(1);

    pk_addr_wrap #(.AW(AW)) u_wrap_step (
        .raw   (step_raw),
        .limit (cfg_wrap_limit),
        .size  (cfg_wrap_size),
        .addr  (step_addr)
    );

    pk_line_acc #(.LINE_BYTES(LINE_BYTES)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (pk_byte_t'(in_byte)),
        .clear (clear),
        .fill  (fill),
        .line  (line)
    );

    always_comb begin
        accept     = !st_q.pend;
        push       = accept && in_valid;
        close      = accept && (flush || last);
        fill_after = fill + CW'(push);
        emit       = (push && (fill == CW'(LINE_BYTES - 1)))
                   || (close && (fill_after != '0));
        load       = push && (fill == '0) && st_q.need;
        done       = st_q.pend && wr_ready;
        clear      = done;

        st_d = st_q;
        if (load)      st_d.cur = start_addr;
        else if (done) st_d.cur = step_addr;

        if (emit) begin
            st_d.pend      = 1'b1;
            st_d.last_pend = accept && last;
        end else if (done) begin
            st_d.pend      = 1'b0;
            st_d.last_pend = 1'b0;
        end

        if (load) st_d.need = 1'b0;
        if (done && st_q.last_pend) st_d.need = 1'b1;
        if (close && last && !emit) st_d.need = 1'b1;
        if (new_addr) st_d.need = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pend      <= 1'b0;
            st_q.last_pend <= 1'b0;
            st_q.need      <= 1'b1;
            st_q.cur       <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready = accept;
    assign wr_valid = st_q.pend;
    assign wr_addr  = st_q.cur;
    assign wr_data  = line;

    // R9: a pending write is held unchanged until accepted
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

    // R9: the byte input is closed while a write is pending
    a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !in_ready);

    // R2: the sixteenth byte raises a write on the next cycle
    a_r2_full_emit: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && fill == CW'(LINE_BYTES - 1)) |=> wr_valid);

    // R4: closing an empty line writes nothing
    a_r4_empty_close: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid && (flush || last) && fill == '0) |=> !wr_valid);

    // R5: an accepted write frees the port for the following cycle
    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> !wr_valid && in_ready);
endmodule

// File: tb/sim_pk_line_writer.sv
`timescale 1ns/1ps
module sim_pk_line_writer;
    localparam int AW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] cfg_dest_base = '0, cfg_coarse_off = '0, cfg_extra_off = '0;
    logic cfg_extra_en = 1'b0, cfg_hdr_skip = 1'b0;
    logic [AW-1:0] cfg_wrap_limit = 16'h7fff, cfg_wrap_size = 16'h0100;
    logic new_addr = 1'b0, in_valid = 1'b0, flush = 1'b0, last = 1'b0, wr_ready = 1'b0;
    logic [7:0] in_byte = '0;
    logic in_ready, wr_valid;
    logic [AW-1:0] wr_addr;
    logic [127:0] wr_data;

    always #2.5 clk = ~clk;

    pk_line_writer u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_dest_base(cfg_dest_base), .cfg_coarse_off(cfg_coarse_off),
        .cfg_extra_off(cfg_extra_off), .cfg_extra_en(cfg_extra_en),
        .cfg_hdr_skip(cfg_hdr_skip), .cfg_wrap_limit(cfg_wrap_limit),
        .cfg_wrap_size(cfg_wrap_size), .new_addr(new_addr),
        .in_valid(in_valid), .in_byte(in_byte), .flush(flush), .last(last),
        .in_ready(in_ready), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    int n_chk = 0, n_fail = 0, n_wr = 0, n_exp = 0;
    string cur_tag = "R1";
    bit done = 1'b0;
    bit rdy_always = 1'b0;
    logic [7:0] lfsr = 8'h5a;

    int m_cnt = 0, m_addr = 0;
    bit m_need = 1'b1;
    logic [127:0] m_line = '0;
    int exp_addr[$];
    logic [127:0] exp_data[$];

    task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int wrapf(int a);
        int r = a;
        if (r > 2 * int'(cfg_wrap_limit) + 1) r = r - 2 * int'(cfg_wrap_size);
        return r & 16'hffff;
    endfunction

    function automatic int start_addr();
        int a = int'(cfg_dest_base) + (cfg_hdr_skip ? 0 : 1)
              + (int'(cfg_coarse_off) & 16'hfff0) + (cfg_extra_en ? int'(cfg_extra_off) : 0);
        return wrapf(a);
    endfunction

    // write port monitor and ready generator (R1, R9)
    logic hold_v = 1'b0;
    logic [AW-1:0] hold_a;
    logic [127:0] hold_d;
    always @(negedge clk) begin
        if (rst_n) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            if (hold_v) begin
                // R9: held write unchanged, input stalled
                chk(wr_valid && wr_addr == hold_a && wr_data == hold_d, "R9",
                    {wr_addr, wr_data[111:0]}, {hold_a, hold_d[111:0]});
                chk(in_ready == 1'b0, "R9", in_ready, 0);
            end
            wr_ready = rdy_always || (lfsr[1:0] != 2'b00);
            hold_v = 1'b0;
            if (wr_valid && wr_ready) begin
                n_wr++;
                if (exp_addr.size() == 0) begin
                    chk(1'b0, "R4", wr_addr, 0);
                end else begin
                    chk(wr_addr == AW'(exp_addr[0]), cur_tag, wr_addr, exp_addr[0]);
                    chk(wr_data == exp_data[0], "R1", wr_data, exp_data[0]);
                    void'(exp_addr.pop_front());
                    void'(exp_data.pop_front());
                end
            end else if (wr_valid) begin
                hold_v = 1'b1; hold_a = wr_addr; hold_d = wr_data;
            end
        end
    end

    task automatic beat(bit v, logic [7:0] b, bit fl, bit ls);
        bit em;
        while (!in_ready) @(negedge clk);
        in_valid = v; in_byte = b; flush = fl; last = ls;
        @(negedge clk);
        in_valid = 1'b0; flush = 1'b0; last = 1'b0;
        if (v) begin
            if (m_cnt == 0 && m_need) begin
                m_addr = start_addr();
                m_need = 1'b0;
            end
            m_line[m_cnt*8 +: 8] = b;
            m_cnt++;
        end
        em = (m_cnt == 16) || ((fl || ls) && m_cnt != 0);
        if (em) begin
            exp_addr.push_back(m_addr);
            exp_data.push_back(m_line);
            n_exp++;
            m_addr = wrapf(m_addr + 1);
            m_line = '0;
            m_cnt = 0;
            if (ls) m_need = 1'b1;
            // R2 R3: write raised right after the closing edge
            chk(wr_valid == 1'b1, (fl || ls) ? "R3" : "R2", wr_valid, 1);
        end else begin
            if (ls) m_need = 1'b1;
            if (fl || ls) chk(wr_valid == 1'b0, "R4", wr_valid, 0);
        end
    endtask

    task automatic send(int len, int seed, bit fl_end, bit ls_end);
        for (int i = 0; i < len; i++)
            beat(1'b1, 8'((seed * 37 + i * 11 + 1) & 255),
                 (i == len - 1) && fl_end, (i == len - 1) && ls_end);
    endtask

    task automatic req_new();
        new_addr = 1'b1;
        @(negedge clk);
        new_addr = 1'b0;
        m_need = 1'b1;
    endtask

    task automatic drain();
        for (int k = 0; k < 200 && (exp_addr.size() != 0 || wr_valid); k++) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wr_valid == 1'b0, "R9", wr_valid, 0);
        chk(in_ready == 1'b1, "R9", in_ready, 1);

        // R6 sweep of start address terms, mixed line lengths
        cur_tag = "R6";
        cfg_extra_off = 16'h0023;
        for (int hs = 0; hs < 2; hs++)
            for (int oe = 0; oe < 2; oe++)
                for (int yi = 0; yi < 3; yi++) begin
                    int idx = hs * 6 + oe * 3 + yi;
                    cfg_hdr_skip = hs[0];
                    cfg_extra_en = oe[0];
                    cfg_coarse_off = (yi == 0) ? 16'h0000 : (yi == 1) ? 16'h001f : 16'h0137;
                    cfg_dest_base = AW'(100 + idx * 5);
                    if (idx[0]) send(7 + 9 * idx, idx, 1'b0, 1'b1);
                    else begin
                        send(7 + 9 * idx, idx, 1'b0, 1'b0);
                        beat(1'b0, 8'h00, 1'b0, 1'b1);
                    end
                end
        drain();

        // R5: separate bursts share one line, then continue at +1
        cur_tag = "R5";
        rdy_always = 1'b1;
        cfg_dest_base = 16'h0200; cfg_hdr_skip = 1'b0; cfg_extra_en = 1'b0; cfg_coarse_off = '0;
        send(3, 40, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        chk(wr_valid == 1'b0, "R5", wr_valid, 0);
        send(4, 41, 1'b0, 1'b0);
        send(9, 42, 1'b0, 1'b0);
        send(5, 43, 1'b1, 1'b0);
        send(16, 44, 1'b1, 1'b0);
        send(2, 45, 1'b0, 1'b1);
        drain();
        rdy_always = 1'b0;

        // R4: empty flush and empty last
        cur_tag = "R4";
        beat(1'b0, 8'h00, 1'b1, 1'b0);
        beat(1'b0, 8'h00, 1'b0, 1'b1);
        send(16, 46, 1'b1, 1'b0);
        beat(1'b0, 8'h00, 1'b1, 1'b0);
        send(1, 47, 1'b0, 1'b1);
        drain();

        // R7: wrap on increment and on start
        cur_tag = "R7";
        cfg_wrap_limit = 16'd20; cfg_wrap_size = 16'd12;
        cfg_dest_base = 16'd38; cfg_hdr_skip = 1'b0;
        send(80, 50, 1'b0, 1'b1);
        cfg_dest_base = 16'd50;
        send(20, 51, 1'b0, 1'b1);
        cfg_hdr_skip = 1'b1; cfg_dest_base = 16'd41;
        send(33, 52, 1'b0, 1'b1);
        drain();

        // R8: config change without last has no effect; new_addr reloads
        cur_tag = "R8";
        cfg_wrap_limit = 16'h7fff; cfg_wrap_size = 16'h0100;
        cfg_dest_base = 16'h0300; cfg_hdr_skip = 1'b0;
        send(20, 60, 1'b0, 1'b0);
        cfg_dest_base = 16'h0400;
        send(20, 61, 1'b1, 1'b0);
        cfg_dest_base = 16'h0500;
        req_new();
        send(16, 62, 1'b0, 1'b0);
        cfg_dest_base = 16'h0600;
        send(10, 63, 1'b0, 1'b1);
        drain();

        chk(n_wr == n_exp, "R4", n_wr, n_exp);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R9 actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule